// File: doc/BRIEF.md
# Infrared Link Transmit Byte Queue

This block buffers outgoing bytes for a fast infrared serial link controller. A CPU-side port writes 16-bit words of which only the low byte is kept. A frame transmit sequencer reads bytes from the head of the queue. The block also decides when the sequencer may begin sending. A start is requested once the buffered byte count reaches a programmable fill threshold. A start is also requested once the count reaches a programmed frame length. The frame length only takes effect if it was written while the sequencer was idle, and it then stays in force for every later frame.

The queue holds either 64 or 32 bytes, chosen by one mode input. Changing that input discards the contents. If the sequencer pops while the queue is empty, the block does three things. It pulses an abort request so the sequencer sends an abort frame instead of the current one. It discards every byte still queued, which drops the frames waiting behind the current one. It sets a sticky underrun flag, which blocks further starts until software clears it.

Top module: `tx_byte_queue`

## Requirements
- R1: A write stores bits 7:0 of `wrData` and ignores bits 15:8. Bytes leave in write order, and `txByte` always shows the oldest stored byte.
- R2: With `depthSel`=1 the queue holds 64 bytes, and with `depthSel`=0 it holds 32. `full` is high exactly when that many bytes are stored, and `empty` is high exactly when none are stored.
- R3: A write while `full` is high is dropped, and the stored contents stay unchanged.
- R4: `txStart` is high when the stored count is nonzero and at least `threshold`, provided `seqBusy` is low and no underrun is flagged.
- R5: A `lenWr` strobe while `seqBusy` is low arms frame-length mode with `frameLen`. While armed, `txStart` is also high when the count is nonzero and at least that length, even if the count is below `threshold`. A `lenWr` strobe while `seqBusy` is high has no effect.
- R6: Frame-length mode stays armed across frames after its first start. It is disarmed only by an underrun or a depth change.
- R7: A `popEn` strobe on a non-empty queue removes the head byte, so the next byte appears on `txByte` one cycle later.
- R8: A `popEn` strobe on an empty queue pulses `abortReq` high for one cycle in the following cycle. It also empties the queue, drops any write made in the same cycle, and disarms frame-length mode.
- R9: `underrunFlag` is set together with `abortReq` and stays set until `clrUnderrun` is asserted. While it is set, `txStart` stays low.
- R10: A change of `depthSel` empties the queue and disarms frame-length mode.
- R11: `txStart` is low while `seqBusy` is high.
- R12: After reset, `empty` is 1, `full` is 0, `txStart` is 0, `abortReq` is 0, `underrunFlag` is 0, and the depth is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe from the CPU side |
| wrData | input | 16 | Write word; only bits 7:0 are stored |
| depthSel | input | 1 | 1 selects 64 bytes, 0 selects 32 bytes |
| threshold | input | 7 | Fill threshold for a start |
| lenWr | input | 1 | Frame-length program strobe |
| frameLen | input | 7 | Frame length in bytes |
| seqBusy | input | 1 | Sequencer is transmitting a frame |
| popEn | input | 1 | Sequencer pop strobe |
| clrUnderrun | input | 1 | Clears the sticky underrun flag |
| txStart | output | 1 | Start request to the sequencer |
| txByte | output | 8 | Head byte of the queue |
| full | output | 1 | Queue holds the selected depth |
| empty | output | 1 | Queue holds no bytes |
| abortReq | output | 1 | One-cycle abort frame request |
| underrunFlag | output | 1 | Sticky underrun status |

## Verification
All state changes on the rising edge in which a strobe is sampled. `txByte`, `full`, `empty` and `underrunFlag` therefore show the new state one cycle after the stimulus. `abortReq` is a register and pulses in that same following cycle. `txStart` combines that state with the current `seqBusy`, `threshold` and `underrunFlag`, so it responds to those inputs at once. The bench drives every input on a falling edge and checks every output at the next falling edge, against a queue model that it updates at the rising edge between them.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Strobes from the control side to the storage side
  typedef struct packed {
    logic push;   // store one byte at the tail
    logic pop;    // drop the head byte
    logic flush;  // return both pointers to zero
    logic deep;   // active depth: 1 = large, 0 = small
  } txq_strobe_t;

endpackage

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int MAX_DEPTH   = 64,
  parameter int SMALL_DEPTH = 32,
  localparam int IDX_W = $clog2(MAX_DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  txq_strobe_t       cs,
  input  logic [7:0]        wrByte,
  output logic [7:0]        rdByte,
  output logic [PTR_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  logic [7:0]       mem [MAX_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, ptrMask, capacity;
  logic [IDX_W-1:0] idxMask, wrIdx, rdIdx;

  // Pointers wrap at twice the active depth; the extra bit tells full from empty
  always_comb begin
    ptrMask  = cs.deep ? PTR_W'(2*MAX_DEPTH - 1) : PTR_W'(2*SMALL_DEPTH - 1);
    idxMask  = cs.deep ? IDX_W'(MAX_DEPTH - 1)   : IDX_W'(SMALL_DEPTH - 1);
    capacity = cs.deep ? PTR_W'(MAX_DEPTH)       : PTR_W'(SMALL_DEPTH);
    wrIdx    = wrPtr[IDX_W-1:0] & idxMask;
    rdIdx    = rdPtr[IDX_W-1:0] & idxMask;
    count    = (wrPtr - rdPtr) & ptrMask;
    full     = (count == capacity);
    empty    = (count == '0);
    rdByte   = mem[rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (cs.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (cs.push) wrPtr <= (wrPtr + 1'b1) & ptrMask;
      if (cs.pop)  rdPtr <= (rdPtr + 1'b1) & ptrMask;
    end
  end

  always_ff @(posedge clk) begin
    if (cs.push) mem[wrIdx] <= wrByte;
  end

  // R2: the two flags never hold together
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R3: a full queue with no pop and no flush stays full
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (full && !cs.pop && !cs.flush) |=> full);

  // R7: a lone pop lowers the count by one
  a_r7_pop_count: assert property (@(posedge clk) disable iff (!rstN)
    (cs.pop && !cs.push && !cs.flush) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             popEn,
  input  logic             depthSel,
  input  logic             seqBusy,
  input  logic             lenWr,
  input  logic [CNT_W-1:0] frameLen,
  input  logic [CNT_W-1:0] threshold,
  input  logic             clrUnderrun,
  input  logic [CNT_W-1:0] count,
  input  logic             full,
  input  logic             empty,
  output txq_strobe_t      cs,
  output logic             txStart,
  output logic             abortReq,
  output logic             underrunFlag
);

  logic             depthQ, depthChg, underrunHit;
  logic             lenArmed;
  logic [CNT_W-1:0] lenQ;
  logic             hitThresh, hitLen;

  always_comb begin
    depthChg    = (depthSel != depthQ);
    underrunHit = popEn && empty;
    cs.flush    = underrunHit || depthChg;
    cs.push     = wrEn && !full && !cs.flush;
    cs.pop      = popEn && !empty && !cs.flush;
    cs.deep     = depthQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ       <= 1'b1;
      lenArmed     <= 1'b0;
      lenQ         <= '0;
      underrunFlag <= 1'b0;
      abortReq     <= 1'b0;
    end else begin
      depthQ   <= depthSel;
      abortReq <= underrunHit;
      if (cs.flush)                lenArmed <= 1'b0;
      else if (lenWr && !seqBusy) begin
        lenArmed <= 1'b1;
        lenQ     <= frameLen;
      end
      if (underrunHit)      underrunFlag <= 1'b1;
      else if (clrUnderrun) underrunFlag <= 1'b0;
    end
  end

  always_comb begin
    hitThresh = (count >= threshold);
    hitLen    = lenArmed && (count >= lenQ);
    txStart   = !seqBusy && !underrunFlag && (count != '0) && (hitThresh || hitLen);
  end

  // R8: the abort pulse comes with the sticky flag and an emptied queue
  a_r8_abort_flag: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> underrunFlag);
  a_r8_abort_empty: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> empty);

  // R9: no start while an underrun is flagged
  a_r9_sticky_blocks: assert property (@(posedge clk) disable iff (!rstN)
    underrunFlag |-> !txStart);

  // R11: no start while the sequencer is busy
  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    seqBusy |-> !txStart);

  // R5: arming only follows a strobe taken while idle
  a_r5_arm_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lenArmed) |-> $past(lenWr && !seqBusy));

endmodule

// File: rtl/tx_byte_queue.sv
module tx_byte_queue
  import txq_pkg::*;
#(
  parameter int MAX_DEPTH   = 64,
  parameter int SMALL_DEPTH = 32,
  localparam int CNT_W = $clog2(MAX_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [15:0]      wrData,
  input  logic             depthSel,
  input  logic [CNT_W-1:0] threshold,
  input  logic             lenWr,
  input  logic [CNT_W-1:0] frameLen,
  input  logic             seqBusy,
  input  logic             popEn,
  input  logic             clrUnderrun,
  output logic             txStart,
  output logic [7:0]       txByte,
  output logic             full,
  output logic             empty,
  output logic             abortReq,
  output logic             underrunFlag
);

  txq_strobe_t      cs;
  logic [CNT_W-1:0] count;
  logic             unusedHi;

  assign unusedHi = ^wrData[15:8];  // reserved upper byte

  txq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .popEn(popEn), .depthSel(depthSel),
    .seqBusy(seqBusy), .lenWr(lenWr), .frameLen(frameLen), .threshold(threshold),
    .clrUnderrun(clrUnderrun), .count(count), .full(full), .empty(empty),
    .cs(cs), .txStart(txStart), .abortReq(abortReq), .underrunFlag(underrunFlag)
  );

  txq_store #(.MAX_DEPTH(MAX_DEPTH), .SMALL_DEPTH(SMALL_DEPTH)) store_i (
    .clk(clk), .rstN(rstN), .cs(cs), .wrByte(wrData[7:0]), .rdByte(txByte),
    .count(count), .full(full), .empty(empty)
  );

endmodule

// File: tb/tx_byte_queue_tb_top.sv
`timescale 1ns/1ps
module tx_byte_queue_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, depthSel = 1, lenWr = 0, seqBusy = 0, popEn = 0, clrUnderrun = 0;
  logic [15:0] wrData = '0;
  logic [6:0]  threshold = 7'd100, frameLen = '0;
  logic txStart, full, empty, abortReq, underrunFlag;
  logic [7:0] txByte;

  int nTests = 0, nFails = 0;
  bit done = 0;

  // model
  logic [7:0] q[$];
  bit mDeep = 1, mArmed = 0, mSticky = 0, mAbort = 0;
  int mLen = 0;

  always #2.5 clk = ~clk;

  tx_byte_queue dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .depthSel(depthSel),
    .threshold(threshold), .lenWr(lenWr), .frameLen(frameLen), .seqBusy(seqBusy),
    .popEn(popEn), .clrUnderrun(clrUnderrun), .txStart(txStart), .txByte(txByte),
    .full(full), .empty(empty), .abortReq(abortReq), .underrunFlag(underrunFlag)
  );

  function automatic int capOf(bit deep);
    return deep ? 64 : 32;
  endfunction

  function automatic bit expStart();
    int n = q.size();
    return !seqBusy && !mSticky && n > 0 && (n >= int'(threshold) || (mArmed && n >= mLen));
  endfunction

  task automatic chk(string tag, string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, req, act, exp);
    end
  endtask

  // Apply the inputs already set, advance one edge, update model, check outputs
  task automatic cycle(string tag);
    bit hit, chg;
    @(posedge clk);
    hit = popEn && q.size() == 0;
    chg = depthSel != mDeep;
    if (hit || chg) begin
      q.delete();
      mArmed = 0;
    end else begin
      bit wasFull = (q.size() == capOf(mDeep));
      if (popEn && q.size() > 0) void'(q.pop_front());
      if (wrEn && !wasFull) q.push_back(wrData[7:0]);
      if (lenWr && !seqBusy) begin
        mArmed = 1;
        mLen = int'(frameLen);
      end
    end
    if (chg) mDeep = depthSel;
    if (hit) mSticky = 1; else if (clrUnderrun) mSticky = 0;
    mAbort = hit;
    @(negedge clk);
    chk(tag, "R2 empty", int'(empty), int'(q.size() == 0));
    chk(tag, "R2 full", int'(full), int'(q.size() == capOf(mDeep)));
    if (q.size() > 0) chk(tag, "R1 head", int'(txByte), int'(q[0]));
    chk(tag, "R4 start", int'(txStart), int'(expStart()));
    chk(tag, "R8 abort", int'(abortReq), int'(mAbort));
    chk(tag, "R9 flag", int'(underrunFlag), int'(mSticky));
  endtask

  task automatic idle();
    wrEn = 0; popEn = 0; lenWr = 0; clrUnderrun = 0;
  endtask

  task automatic writeN(int n, string tag);
    for (int i = 0; i < n; i++) begin
      idle(); wrEn = 1; wrData = 16'($urandom());
      cycle(tag);
    end
    idle();
  endtask

  task automatic popN(int n, string tag);
    for (int i = 0; i < n; i++) begin
      idle(); popEn = 1;
      cycle(tag);
    end
    idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R12: reset state
    chk("reset", "R12 empty", int'(empty), 1);
    chk("reset", "R12 full", int'(full), 0);
    chk("reset", "R12 start", int'(txStart), 0);
    chk("reset", "R12 abort", int'(abortReq), 0);
    chk("reset", "R12 flag", int'(underrunFlag), 0);
    rstN = 1;
    @(negedge clk);

    // R1: upper byte of the write is ignored
    wrEn = 1; wrData = 16'hAB12; cycle("R1");
    chk("R1", "R1 lowbyte", int'(txByte), 8'h12);
    idle();

    // R4: threshold start at 3 bytes, R11 blocked while busy
    threshold = 7'd3;
    writeN(2, "R4");
    chk("R4", "R4 at3", int'(txStart), 1);
    seqBusy = 1; cycle("R11");
    chk("R11", "R11 busy", int'(txStart), 0);
    seqBusy = 0;

    // R7 drain, then R8 pop on empty
    popN(3, "R7");
    chk("R7", "R7 drained", int'(empty), 1);
    popEn = 1; wrEn = 1; wrData = 16'h0055; cycle("R8");
    idle();
    chk("R8", "R8 abortpulse", int'(abortReq), 1);
    chk("R8", "R8 flushed", int'(empty), 1);
    cycle("R8");
    chk("R8", "R8 onecycle", int'(abortReq), 0);
    writeN(4, "R9");
    chk("R9", "R9 blocked", int'(txStart), 0);
    clrUnderrun = 1; cycle("R9"); idle();
    chk("R9", "R9 cleared", int'(txStart), 1);
    popN(4, "R9");

    // R5: frame length arms only when idle
    threshold = 7'd50;
    seqBusy = 1; lenWr = 1; frameLen = 7'd4; cycle("R5"); idle(); seqBusy = 0;
    writeN(4, "R5");
    chk("R5", "R5 busyignored", int'(txStart), 0);
    popN(4, "R5");
    lenWr = 1; cycle("R5"); idle();
    writeN(4, "R5");
    chk("R5", "R5 lenstart", int'(txStart), 1);
    // R6: next frame also starts at frame length
    seqBusy = 1; popN(4, "R6"); seqBusy = 0;
    writeN(4, "R6");
    chk("R6", "R6 secondframe", int'(txStart), 1);
    popN(4, "R6");

    // R2/R3: fill the large depth and overrun it
    threshold = 7'd100;
    writeN(66, "R3");
    chk("R3", "R3 full64", int'(full), 1);
    popN(64, "R3");
    chk("R3", "R3 exactly64", int'(empty), 1);

    // R10: depth change flushes and disarms; small depth full at 32
    writeN(5, "R10");
    depthSel = 0; cycle("R10");
    chk("R10", "R10 flushed", int'(empty), 1);
    writeN(33, "R2");
    chk("R2", "R2 full32", int'(full), 1);
    depthSel = 1; cycle("R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      idle();
      wrEn = ($urandom_range(0, 99) < 55);
      wrData = 16'($urandom());
      popEn = ($urandom_range(0, 99) < 35);
      seqBusy = ($urandom_range(0, 99) < 20);
      lenWr = ($urandom_range(0, 99) < 4);
      frameLen = 7'($urandom_range(0, 40));
      clrUnderrun = ($urandom_range(0, 99) < 6);
      if ($urandom_range(0, 99) < 2) threshold = 7'($urandom_range(0, 70));
      if ($urandom_range(0, 999) < 5) depthSel = ~depthSel;
      cycle("rand");
    end
    idle(); seqBusy = 0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule